// File: doc/BRIEF.md
# Dual-Mode Task and Interrupt Front-End

This block sits in front of two engines that share one register space: an address resolver and an authenticated cipher. A mode register picks which engine is live. The block sends the shared start and stop task strobes to that engine alone. Each engine has its own interrupt-enable register and its own latched event flags. The single level-sensitive interrupt line is driven only by the live engine's masked flags.

Software writes the mode code, sets or clears bits in the live engine's enable register, and clears event flags by writing zeros. The engines send one-cycle event pulses and a busy level. If software moves the mode away from an engine while that engine reports busy, the block raises a one-cycle configuration-error pulse.

Top module: `dual_mode_dispatch`

## Requirements
- R1: `task_start`/`task_stop` appear on `res_start`/`res_stop` in the same cycle when the mode is 1 (resolver), and on `ciph_start`/`ciph_stop` when the mode is 2 (cipher). With mode 0 or 3, all four task outputs stay low.
- R2: In resolver mode, `irq` is the OR of the four resolver flags, each ANDed with its enable bit. Bit 0 is END, bit 1 is RESOLVED, bit 2 is NOTRESOLVED and bit 3 is ERROR, for the flags, the enables and `res_evt`.
- R3: In cipher mode, `irq` is the OR of the two cipher flags, each ANDed with its enable bit. Bit 0 is END and bit 1 is ERROR, for the flags, the enables and `ciph_evt`. Bits 3:2 of `ien_data` are ignored for the cipher.
- R4: Each mode keeps its own enable register. `ien_set` ORs `ien_data` into the register of the current mode. `ien_clr` removes the `ien_data` bits from it. When both are given together, set wins on overlapping bits. With mode 0 or 3, both writes are ignored.
- R5: The mode that is not selected contributes nothing to `irq`. With mode 0 or 3, `irq` is low whatever the flags and enables hold.
- R6: An engine event pulse sets its flag on the next clock edge, in any mode. `evt_wr` clears the current mode's flags where `evt_wr_data` holds 0 and keeps them where it holds 1. A pulse in the same cycle wins over the clear.
- R7: A mode write with a new code, while the engine of the current mode reports busy, gives a one-cycle `cfg_err` pulse in the next cycle. The mode write still takes effect. No pulse is given for a write of the same code, or when the current engine is idle.
- R8: After reset the mode is 0, and all enables and flags are clear, so `irq`, `cfg_err` and all task outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr | input | 1 | Write strobe for the mode register |
| mode_wdata | input | 2 | New mode code (1 resolver, 2 cipher) |
| ien_set | input | 1 | Set bits in the current mode's enable register |
| ien_clr | input | 1 | Clear bits in the current mode's enable register |
| ien_data | input | 4 | Bit mask for set and clear |
| evt_wr | input | 1 | Write to the current mode's event flags |
| evt_wr_data | input | 4 | Flag keep mask (0 clears the flag) |
| task_start | input | 1 | Shared start task |
| task_stop | input | 1 | Shared stop task |
| res_busy | input | 1 | Resolver engine is running |
| res_evt | input | 4 | Resolver event pulses |
| ciph_busy | input | 1 | Cipher engine is running |
| ciph_evt | input | 2 | Cipher event pulses |
| res_start | output | 1 | Start task routed to the resolver |
| res_stop | output | 1 | Stop task routed to the resolver |
| ciph_start | output | 1 | Start task routed to the cipher |
| ciph_stop | output | 1 | Stop task routed to the cipher |
| irq | output | 1 | Shared level interrupt |
| cfg_err | output | 1 | Pulse on an illegal mode change |

## Verification
The interrupt mapping is driven with one-hot enable and event pairs in both modes. Matched bit positions raise the line and mismatched positions do not, which tells the resolver layout apart from the cipher layout. Other patterns put events on the non-selected engine, set enable bits above the cipher's width, or use mode codes 0 and 3. These show that only the live mode's masked flags reach the line. Directed sequences cover the following:
- that each mode keeps its own enable register across a mode switch;
- set-versus-clear priority;
- flag clearing by zero bits;
- the busy and same-code cases of the configuration-error pulse.

// File: rtl/dual_mode_dispatch.sv
module dual_mode_dispatch #(
  parameter logic [1:0] MODE_RES  = 2'd1,
  parameter logic [1:0] MODE_CIPH = 2'd2,
  parameter int         RES_EVTS  = 4,
  parameter int         CIPH_EVTS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_wr,
  input  logic [1:0]           mode_wdata,
  input  logic                 ien_set,
  input  logic                 ien_clr,
  input  logic [RES_EVTS-1:0]  ien_data,
  input  logic                 evt_wr,
  input  logic [RES_EVTS-1:0]  evt_wr_data,
  input  logic                 task_start,
  input  logic                 task_stop,
  input  logic                 res_busy,
  input  logic [RES_EVTS-1:0]  res_evt,
  input  logic                 ciph_busy,
  input  logic [CIPH_EVTS-1:0] ciph_evt,
  output logic                 res_start,
  output logic                 res_stop,
  output logic                 ciph_start,
  output logic                 ciph_stop,
  output logic                 irq,
  output logic                 cfg_err
);

  logic [1:0]           mode_q;
  logic [RES_EVTS-1:0]  res_ien_q, res_flg_q;
  logic [CIPH_EVTS-1:0] ciph_ien_q, ciph_flg_q;
  logic                 cfg_err_q;

  wire is_res  = (mode_q == MODE_RES);
  wire is_ciph = (mode_q == MODE_CIPH);

  assign res_start  = task_start & is_res;
  assign res_stop   = task_stop  & is_res;
  assign ciph_start = task_start & is_ciph;
  assign ciph_stop  = task_stop  & is_ciph;

  assign irq = (is_res  & |(res_flg_q  & res_ien_q)) |
               (is_ciph & |(ciph_flg_q & ciph_ien_q));
  assign cfg_err = cfg_err_q;

  wire busy_now  = (is_res & res_busy) | (is_ciph & ciph_busy);
  wire bad_write = mode_wr & (mode_wdata != mode_q) & busy_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= '0;
      cfg_err_q <= 1'b0;
    end else begin
      cfg_err_q <= bad_write;
      if (mode_wr) mode_q <= mode_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_ien_q  <= '0;
      ciph_ien_q <= '0;
    end else begin
      if (is_res && (ien_set || ien_clr))
        res_ien_q <= (res_ien_q & ~(ien_clr ? ien_data : '0)) |
                     (ien_set ? ien_data : '0);
      if (is_ciph && (ien_set || ien_clr))
        ciph_ien_q <= (ciph_ien_q & ~(ien_clr ? ien_data[CIPH_EVTS-1:0] : '0)) |
                      (ien_set ? ien_data[CIPH_EVTS-1:0] : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_flg_q  <= '0;
      ciph_flg_q <= '0;
    end else begin
      res_flg_q  <= ((evt_wr && is_res)  ? (res_flg_q & evt_wr_data) : res_flg_q) | res_evt;
      ciph_flg_q <= ((evt_wr && is_ciph) ? (ciph_flg_q & evt_wr_data[CIPH_EVTS-1:0]) : ciph_flg_q)
                    | ciph_evt;
    end
  end

  assert_task_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !((res_start || res_stop) && (ciph_start || ciph_stop)));

  assert_idle_mode_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_res && !is_ciph) |-> (!irq && !res_start && !ciph_start));

  assert_set_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_set && is_res) |=> ((res_ien_q & $past(ien_data)) == $past(ien_data)));

  assert_clr_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_clr && !ien_set && is_res) |=> ((res_ien_q & $past(ien_data)) == '0));

  assert_evt_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_evt != '0) |=> ((res_flg_q & $past(res_evt)) == $past(res_evt)));

  assert_cfg_err_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> ($past(mode_wr) && $past(busy_now)));

endmodule

// File: tb/dual_mode_dispatch_tb_top.sv
module dual_mode_dispatch_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       mode_wr = 0, ien_set = 0, ien_clr = 0, evt_wr = 0;
  logic [1:0] mode_wdata = 0;
  logic [3:0] ien_data = 0, evt_wr_data = 4'hF, res_evt = 0;
  logic       task_start = 0, task_stop = 0, res_busy = 0, ciph_busy = 0;
  logic [1:0] ciph_evt = 0;
  logic res_start, res_stop, ciph_start, ciph_stop, irq, cfg_err;

  int checks = 0, errors = 0;

  dual_mode_dispatch dut_i (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .ien_set(ien_set), .ien_clr(ien_clr), .ien_data(ien_data),
    .evt_wr(evt_wr), .evt_wr_data(evt_wr_data),
    .task_start(task_start), .task_stop(task_stop),
    .res_busy(res_busy), .res_evt(res_evt), .ciph_busy(ciph_busy), .ciph_evt(ciph_evt),
    .res_start(res_start), .res_stop(res_stop), .ciph_start(ciph_start),
    .ciph_stop(ciph_stop), .irq(irq), .cfg_err(cfg_err));

  // {mode[14:13], ien[12:9], res_evt[8:5], ciph_evt[4:3], exp_irq[2], pad[1:0]}
  localparam logic [14:0] VEC [12] = '{
    {2'd1, 4'b0001, 4'b0001, 2'b00, 1'b1, 2'b0},
    {2'd1, 4'b0010, 4'b0001, 2'b00, 1'b0, 2'b0},
    {2'd1, 4'b1000, 4'b1000, 2'b00, 1'b1, 2'b0},
    {2'd1, 4'b0100, 4'b0100, 2'b00, 1'b1, 2'b0},
    {2'd1, 4'b1111, 4'b0000, 2'b11, 1'b0, 2'b0},
    {2'd2, 4'b0001, 4'b0000, 2'b01, 1'b1, 2'b0},
    {2'd2, 4'b0010, 4'b0000, 2'b10, 1'b1, 2'b0},
    {2'd2, 4'b0001, 4'b0000, 2'b10, 1'b0, 2'b0},
    {2'd2, 4'b1100, 4'b0000, 2'b11, 1'b0, 2'b0},
    {2'd2, 4'b0011, 4'b1111, 2'b00, 1'b0, 2'b0},
    {2'd0, 4'b1111, 4'b1111, 2'b11, 1'b0, 2'b0},
    {2'd3, 4'b1111, 4'b1111, 2'b11, 1'b0, 2'b0}};

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic set_mode(input logic [1:0] m);
    mode_wr = 1; mode_wdata = m; tick(); mode_wr = 0;
  endtask

  task automatic scrub();
    for (int m = 1; m <= 2; m++) begin
      set_mode(m[1:0]);
      ien_clr = 1; ien_data = 4'hF; evt_wr = 1; evt_wr_data = 4'h0;
      tick();
      ien_clr = 0; evt_wr = 0; evt_wr_data = 4'hF;
    end
  endtask

  task automatic set_ien(input logic [3:0] d);
    ien_set = 1; ien_data = d; tick(); ien_set = 0;
  endtask

  task automatic pulse(input logic [3:0] r, input logic [1:0] c);
    res_evt = r; ciph_evt = c; tick(); res_evt = 0; ciph_evt = 0;
  endtask

  initial begin
    #(4 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: got hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick();
    chk(irq, 0, "R8 irq"); chk(cfg_err, 0, "R8 cfg_err");
    task_start = 1; #0.5;
    chk(res_start | ciph_start, 0, "R8 tasks");
    task_start = 0;
    rst_n = 1; tick();

    for (int i = 0; i < 12; i++) begin
      scrub();
      set_mode(VEC[i][14:13]);
      set_ien(VEC[i][12:9]);
      pulse(VEC[i][8:5], VEC[i][4:3]);
      chk(irq, VEC[i][2], (VEC[i][14:13] == 2'd2) ? "R3 vector" :
                          (VEC[i][14:13] == 2'd1) ? "R2 vector" : "R5 vector");
    end

    // R1 routing
    for (int m = 0; m < 4; m++) begin
      set_mode(m[1:0]);
      task_start = 1; #0.5;
      chk(res_start,  m == 1, "R1 res_start");
      chk(ciph_start, m == 2, "R1 ciph_start");
      task_start = 0; task_stop = 1; #0.5;
      chk(res_stop,  m == 1, "R1 res_stop");
      chk(ciph_stop, m == 2, "R1 ciph_stop");
      task_stop = 0; tick();
    end

    // R4 clear and set priority
    scrub(); set_mode(2'd1); set_ien(4'hF); pulse(4'b0001, 2'b00);
    chk(irq, 1, "R4 setup");
    ien_clr = 1; ien_data = 4'b0001; tick(); ien_clr = 0;
    chk(irq, 0, "R4 clear");
    ien_set = 1; ien_clr = 1; ien_data = 4'b0001; tick(); ien_set = 0; ien_clr = 0;
    chk(irq, 1, "R4 set wins");

    // R4 separate registers across mode switch
    set_mode(2'd2); pulse(4'b0000, 2'b01);
    chk(irq, 0, "R4 cipher enable untouched");
    set_mode(2'd1);
    chk(irq, 1, "R4 resolver enable kept");
    set_mode(2'd0);
    chk(irq, 0, "R5 mode off gates irq");
    set_ien(4'b0000);
    ien_clr = 1; ien_data = 4'hF; tick(); ien_clr = 0;
    set_mode(2'd1);
    chk(irq, 1, "R4 write ignored in mode 0");

    // R6 clear by zero bits, keep by ones, event wins
    evt_wr = 1; evt_wr_data = 4'b1110; tick(); evt_wr = 0; evt_wr_data = 4'hF;
    chk(irq, 0, "R6 zero clears");
    pulse(4'b0001, 2'b00);
    evt_wr = 1; evt_wr_data = 4'b0001; tick(); evt_wr = 0; evt_wr_data = 4'hF;
    chk(irq, 1, "R6 one keeps");
    evt_wr = 1; evt_wr_data = 4'b0000; res_evt = 4'b0001; tick();
    evt_wr = 0; evt_wr_data = 4'hF; res_evt = 0;
    chk(irq, 1, "R6 event wins");

    // R7 configuration error
    set_mode(2'd1); res_busy = 1;
    set_mode(2'd2);
    chk(cfg_err, 1, "R7 away while busy");
    tick();
    chk(cfg_err, 0, "R7 one cycle");
    set_mode(2'd1);
    chk(cfg_err, 0, "R7 resolver busy not current");
    set_mode(2'd1);
    chk(cfg_err, 0, "R7 same code");
    res_busy = 0; set_mode(2'd2);
    chk(cfg_err, 0, "R7 idle");
    ciph_busy = 1; set_mode(2'd0);
    chk(cfg_err, 1, "R7 cipher busy");
    ciph_busy = 0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule